// File: doc/BRIEF.md
# Outstanding Request Tracker with Same-Line Ordering Stall

This block sits between a traffic source and the memory side of a chip. It admits requests from the source, gives each one a slot in a table of outstanding work, and names the slot (its ID) on a one-cycle issue output. It keeps the slot until the memory side reports that request finished by sending back the ID. Each slot holds the request's opcode, address and write data, plus a live flag.

Before taking a request, the block compares its cache line against every live slot. Two requests to one line are never outstanding together, so writes to a line leave in the order the source sent them. A request also needs a free slot and one credit for the receiver's input buffer. The credit counter drops by one per admission and rises by one per credit-return pulse. The source keeps its request on the input while `req_ready` is low, so no later request can pass a stalled one.

A small admission state machine sorts each cycle into one of four states, checked in priority order. ST_HAZARD: the head request's line is live. ST_FULL: no slot is free. ST_NOCRED: no credit is left. ST_OPEN: the request may enter. The state is recomputed every cycle from the live table and the credit count. The named transitions are OPEN→HAZARD (a same-line request arrives), HAZARD→OPEN (the blocking slot retires), OPEN→FULL and FULL→OPEN (the last slot fills, then a completion frees one), and OPEN→NOCRED and NOCRED→OPEN (credits run out, then a return arrives). The registered state feeds a check that a held, stalled request is only released by a completion.

Top module: `req_tracker`

## Requirements
- R1: After reset all slots are free, the credit count equals CREDIT_MAX, `req_ready` is high and `iss_valid` is low.
- R2: A request accepted in cycle t (`req_valid` and `req_ready` high at the edge) shows in cycle t+1 as `iss_valid` high for exactly that cycle. In that cycle `iss_id` gives the slot, and `iss_op`, `iss_addr` and `iss_data` equal the accepted values.
- R3: When all N_ENTRIES slots are live, `req_ready` is low.
- R4: When the request's line address (address bits above bit 5, with 64-byte lines) equals the line of any live slot, `req_ready` is low. Offset bits [5:0] play no part in the comparison.
- R5: `req_ready` is low while the credit count is zero. Each accepted request lowers the count by one, and each `crd_ret` pulse raises it by one.
- R6: A new request takes the free slot with the lowest index.
- R7: `cmp_valid` with `cmp_id` frees that slot at the end of the same cycle. A request blocked by that slot, or by a full table, may be accepted in the next cycle.
- R8: The credit count never goes above CREDIT_MAX: a `crd_ret` pulse at the maximum is ignored. An acceptance and a return in the same cycle leave the count unchanged.
- R9: No two live slots ever hold the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source offers a request |
| req_ready | output | 1 | Request is accepted this cycle |
| req_op | input | OP_W | Request opcode |
| req_addr | input | ADDR_W | Request byte address |
| req_data | input | DATA_W | Request write data |
| iss_valid | output | 1 | Issue pulse for a newly admitted request |
| iss_id | output | $clog2(N_ENTRIES) | Slot ID of the issued request |
| iss_op | output | OP_W | Opcode of the issued request |
| iss_addr | output | ADDR_W | Address of the issued request |
| iss_data | output | DATA_W | Write data of the issued request |
| cmp_valid | input | 1 | Completion strobe |
| cmp_id | input | $clog2(N_ENTRIES) | Slot ID being retired |
| crd_ret | input | 1 | Receiver freed one buffer slot |

## Verification
The bench builds the tracker with the full 32 slots and CREDIT_MAX set to 4. The small credit pool makes credit starvation, saturation at the maximum and same-cycle take-and-return cases reachable within a few requests. Returning a credit on every request then lets the bench fill all 32 slots and reach the full-table stall. Line addresses are chosen to share lines with live slots at different byte offsets. Completions are aimed at middle slots to test reuse in lowest-index order.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_HAZARD  = 2'd1,
        ST_FULL    = 2'd2,
        ST_NOCRED  = 2'd3
    } adm_state_e;
endpackage

// File: rtl/trk_credit.sv
module trk_credit #(
    parameter int CREDIT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam int CW = $clog2(CREDIT_MAX + 1);
    localparam logic [CW-1:0] CMAX = CW'(CREDIT_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CMAX;
        end else begin
            unique case ({take, give})
                2'b10:   cnt_q <= cnt_q - 1'b1;
                2'b01:   if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign avail = (cnt_q != '0);

    assert_credit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt_q != '0);
    assert_take_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give) |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_pair_neutral_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> $stable(cnt_q));
endmodule

// File: rtl/trk_scan.sv
module trk_scan #(
    parameter int N  = 32,
    parameter int LW = 26,
    parameter int IW = 5
) (
    input  logic [N-1:0]    live,
    input  logic [N*LW-1:0] lines,
    input  logic [LW-1:0]   want_line,
    output logic            hit,
    output logic            free_any,
    output logic [IW-1:0]   free_idx
);
    always_comb begin
        hit      = 1'b0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i] && (lines[i*LW +: LW] == want_line)) hit = 1'b1;
            if (!live[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import trk_pkg::*;
#(
    parameter int N_ENTRIES  = 32,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int OP_W       = 4,
    parameter int LINE_BYTES = 64,
    parameter int CREDIT_MAX = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [OP_W-1:0]              req_op,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_data,
    output logic                         iss_valid,
    output logic [$clog2(N_ENTRIES)-1:0] iss_id,
    output logic [OP_W-1:0]              iss_op,
    output logic [ADDR_W-1:0]            iss_addr,
    output logic [DATA_W-1:0]            iss_data,
    input  logic                         cmp_valid,
    input  logic [$clog2(N_ENTRIES)-1:0] cmp_id,
    input  logic                         crd_ret
);
    localparam int OFS = $clog2(LINE_BYTES);
    localparam int LW  = ADDR_W - OFS;
    localparam int IW  = $clog2(N_ENTRIES);

    logic [N_ENTRIES-1:0]    live_q;
    logic [OP_W-1:0]         op_q   [N_ENTRIES];
    logic [ADDR_W-1:0]       addr_q [N_ENTRIES];
    logic [DATA_W-1:0]       data_q [N_ENTRIES];
    logic [N_ENTRIES*LW-1:0] lines_flat;

    logic          hit, free_any, cred_ok, take;
    logic [IW-1:0] free_idx;
    logic          iss_v_q;
    logic [IW-1:0] iss_id_q;
    adm_state_e    cur_state, state_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_line
        assign lines_flat[g*LW +: LW] = addr_q[g][ADDR_W-1:OFS];
    end

    trk_scan #(.N(N_ENTRIES), .LW(LW), .IW(IW)) u_scan (
        .live      (live_q),
        .lines     (lines_flat),
        .want_line (req_addr[ADDR_W-1:OFS]),
        .hit       (hit),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    trk_credit #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .give  (crd_ret),
        .avail (cred_ok)
    );

    // Admission classification, priority hazard > full > no credit
    always_comb begin
        if (hit)            cur_state = ST_HAZARD;
        else if (!free_any) cur_state = ST_FULL;
        else if (!cred_ok)  cur_state = ST_NOCRED;
        else                cur_state = ST_OPEN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= cur_state;
    end

    always_comb begin
        unique case (cur_state)
            ST_OPEN:   req_ready = 1'b1;
            ST_HAZARD: req_ready = 1'b0;
            ST_FULL:   req_ready = 1'b0;
            ST_NOCRED: req_ready = 1'b0;
        endcase
    end

    assign take = req_valid && req_ready;

    // Slot table: retire first, then allocate (they never touch one live slot)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            if (cmp_valid) live_q[cmp_id] <= 1'b0;
            if (take)      live_q[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            op_q[free_idx]   <= req_op;
            addr_q[free_idx] <= req_addr;
            data_q[free_idx] <= req_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_v_q  <= 1'b0;
            iss_id_q <= '0;
        end else begin
            iss_v_q <= take;
            if (take) iss_id_q <= free_idx;
        end
    end

    assign iss_valid = iss_v_q;
    assign iss_id    = iss_id_q;
    assign iss_op    = op_q[iss_id_q];
    assign iss_addr  = addr_q[iss_id_q];
    assign iss_data  = data_q[iss_id_q];

    assert_issue_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (iss_valid && live_q[iss_id]));
    assert_retire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !(take && free_idx == cmp_id)) |=> !live_q[$past(cmp_id)]);
    assert_stall_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HAZARD && req_valid && $past(req_valid) && $stable(req_addr)
         && cur_state != ST_HAZARD) |-> $past(cmp_valid));
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&live_q) |-> !take);

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                for (int j = i + 1; j < N_ENTRIES; j++) begin
                    assert_unique_line_R9: assert (!(live_q[i] && live_q[j] &&
                        addr_q[i][ADDR_W-1:OFS] == addr_q[j][ADDR_W-1:OFS]));
                end
                if (take && i < int'(free_idx)) begin
                    assert_lowest_slot_R6: assert (live_q[i]);
                end
            end
        end
    end
endmodule

// File: tb/test_req_tracker.sv
module test_req_tracker;
    localparam int N  = 32;
    localparam int CM = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [3:0]  req_op;
    logic [31:0] req_addr, req_data;
    logic        iss_valid;
    logic [4:0]  iss_id;
    logic [3:0]  iss_op;
    logic [31:0] iss_addr, iss_data;
    logic        cmp_valid;
    logic [4:0]  cmp_id;
    logic        crd_ret;

    always #5 clk = ~clk;

    req_tracker #(.N_ENTRIES(N), .CREDIT_MAX(CM)) i_req_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .iss_valid(iss_valid), .iss_id(iss_id), .iss_op(iss_op),
        .iss_addr(iss_addr), .iss_data(iss_data),
        .cmp_valid(cmp_valid), .cmp_id(cmp_id), .crd_ret(crd_ret)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_live [N];
    int          m_line [N];
    int          m_cred;
    bit          e_iv;
    int          e_id;
    logic [3:0]  e_op;
    logic [31:0] e_addr, e_data;
    bit          last_ready;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < N; i++) if (!m_live[i]) return i;
        return -1;
    endfunction

    task automatic step(bit v, logic [31:0] a, logic [3:0] op, bit cv, int cid, bit cr);
        bit hz, ok;
        int lf;
        string tag;
        @(negedge clk);
        req_valid = v; req_addr = a; req_op = op; req_data = a ^ 32'h5A5A_0000;
        cmp_valid = cv; cmp_id = 5'(cid); crd_ret = cr;
        #1;
        hz = 0;
        for (int i = 0; i < N; i++) if (m_live[i] && m_line[i] == int'(a[31:6])) hz = 1;
        lf = low_free();
        ok = !hz && lf >= 0 && m_cred > 0;
        tag = hz ? "R4" : (lf < 0) ? "R3" : (m_cred == 0) ? "R5" : "R1";
        check(tag, int'(req_ready), int'(ok));
        last_ready = req_ready;
        check("R2", int'(iss_valid), int'(e_iv));
        if (e_iv) begin
            check("R6", int'(iss_id), e_id);
            check("R2", int'(iss_addr), int'(e_addr));
            check("R2", int'(iss_op), int'(e_op));
            check("R2", int'(iss_data), int'(e_data));
        end
        @(posedge clk);
        if (cv) m_live[cid] = 0;
        e_iv = v && ok;
        if (e_iv) begin
            m_live[lf] = 1; m_line[lf] = int'(a[31:6]);
            e_id = lf; e_addr = a; e_op = op; e_data = a ^ 32'h5A5A_0000;
        end
        if (e_iv && !cr) m_cred--;
        else if (cr && !e_iv && m_cred < CM) m_cred++;
    endtask

    task automatic idle(bit cr);
        step(0, 32'h0, 4'h0, 0, 0, cr);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_live[i] = 0; m_line[i] = 0; end
        m_cred = CM; e_iv = 0; e_id = 0; e_op = 0; e_addr = 0; e_data = 0;
        rst_n = 0; req_valid = 0; req_addr = 0; req_op = 0; req_data = 0;
        cmp_valid = 0; cmp_id = 0; crd_ret = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R1", int'(req_ready), 1);
        check("R1", int'(iss_valid), 0);

        // Four distinct lines use up all credits; slots 0..3
        for (int i = 0; i < 4; i++) step(1, 32'h1000 + 32'(i) * 64, 4'(i + 1), 0, 0, 0);
        step(1, 32'h2000, 4'h7, 0, 0, 0);
        check("R5", int'(last_ready), 0);
        step(0, 32'h2000, 4'h7, 0, 0, 1);
        step(1, 32'h2000, 4'h7, 0, 0, 0);        // slot 4
        check("R5", int'(last_ready), 1);

        // Returns beyond the maximum are dropped (R8)
        repeat (7) idle(1);
        for (int i = 0; i < 4; i++) step(1, 32'h3000 + 32'(i) * 64, 4'h2, 0, 0, 0);
        step(1, 32'h3100, 4'h2, 0, 0, 0);
        check("R8", int'(last_ready), 0);
        idle(1);

        // Same line, different offset: stall until slot 0 retires (R4, R7)
        step(1, 32'h1008, 4'h9, 0, 0, 0);
        check("R4", int'(last_ready), 0);
        step(1, 32'h1008, 4'h9, 0, 0, 0);
        step(1, 32'h1008, 4'h9, 1, 0, 0);
        check("R7", int'(last_ready), 0);
        step(1, 32'h1008, 4'h9, 0, 0, 0);        // reuses slot 0
        check("R7", int'(last_ready), 1);

        // Take and return in one cycle cancel (R8)
        idle(1);
        step(1, 32'h4000, 4'h3, 0, 0, 1);
        step(1, 32'h4040, 4'h3, 0, 0, 0);
        check("R8", int'(last_ready), 1);
        step(1, 32'h4080, 4'h3, 0, 0, 0);
        check("R8", int'(last_ready), 0);

        // Free middle slots, then fill the table (R6, R3)
        step(0, 32'h0, 4'h0, 1, 2, 1);
        step(0, 32'h0, 4'h0, 1, 5, 1);
        repeat (3) idle(1);
        for (int i = 0; i < 40; i++) begin
            if (low_free() < 0) break;
            step(1, 32'h8000 + 32'(i) * 64, 4'h5, 0, 0, 1);
        end
        idle(0);
        step(1, 32'h9000, 4'h6, 0, 0, 0);
        check("R3", int'(last_ready), 0);
        step(1, 32'h9000, 4'h6, 1, 10, 0);
        step(1, 32'h9000, 4'h6, 0, 0, 0);        // slot 10
        check("R3", int'(last_ready), 1);
        idle(0);
        idle(0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule